// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits in a CAN receive path between the bit sampler and the frame parser. Each sampled bus bit arrives with a one-cycle valid strobe. The block keeps a short history of raw bits and spots stuff bits, which are the bits a transmitter inserts after five equal bits. It drops them from the stream and forwards every other bit to the parser. Each forwarded bit carries its destuffed position in the frame, where position 0 is the start-of-frame bit. Each removed stuff bit raises a separate strobe for monitoring.

The fixed-form end of a frame (CRC delimiter, acknowledge and end-of-frame) is never stuffed. Once the parser has decoded the length, it hands the block the position of the last data bit. Beyond a fixed distance from that position, stuff detection is switched off. Until that position is given, detection stays on. A frame-done pulse from the parser clears the block for the next frame.

Top module: `can_bit_destuffer`

## Requirements
- R1: During and after a synchronous reset, `frm_vld` and `stf_vld` are low and `frm_idx` is 0.
- R2: A raw bit accepted with `raw_vld` high is reported exactly one clock later: either `frm_vld` pulses with `frm_bit` equal to the raw value, or `stf_vld` pulses. Neither output pulses in a cycle that follows a clock with `raw_vld` low.
- R3: `frm_idx` of the first forwarded bit after reset or frame-done is 0. It rises by exactly one for each later forwarded bit.
- R4: A raw bit is a stuff bit when the five raw bits before it are all equal and it has the opposite value. A stuff bit pulses `stf_vld`, is not forwarded and does not advance the index. `frm_idx` holds its value while `stf_vld` pulses.
- R5: A raw bit equal to the five raw bits before it is forwarded as a frame bit. No error of any kind is flagged.
- R6: The history is built from raw bits with stuff bits included. A stuff bit can therefore be one of the five equal bits that precede a later stuff bit.
- R7: While fewer than five raw bits have arrived since reset or frame-done, no bit is treated as a stuff bit.
- R8: Until a last-data position has been loaded, stuff detection is enabled at every frame index.
- R9: A pulse on `last_set` loads `last_pos`. After that, detection applies only while the candidate's frame index (the count of bits forwarded so far in the frame) is at most `last_pos` + 16. Beyond that point a bit that fits the stuff pattern is forwarded as a frame bit.
- R10: A `frame_done` pulse clears the history, the frame index and the loaded last-data position. A raw bit that arrives in the same cycle is discarded, and no output pulses in the following cycle.
- R11: `frm_vld` and `stf_vld` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_vld | input | 1 | Strobe: a sampled bus bit is present |
| raw_bit | input | 1 | Sampled bus value (0 dominant, 1 recessive) |
| last_set | input | 1 | Strobe: load the last-data-bit position |
| last_pos | input | IDX_W | Frame index of the last data bit |
| frame_done | input | 1 | Strobe from the parser: frame finished, clear state |
| frm_vld | output | 1 | Strobe: a frame bit is forwarded |
| frm_bit | output | 1 | Value of the forwarded frame bit |
| frm_idx | output | IDX_W | Destuffed frame index of the forwarded bit |
| stf_vld | output | 1 | Strobe: a stuff bit was removed |

## Verification
A table-driven stream exercises the main detection path. It runs a run of five dominant bits that ends in an opposite bit, a recessive run that starts with a stuff bit, and a sixth equal bit after a run. These patterns separate a correct detector from one that forgets stuff bits in its history or one that flags equal bits. Directed sequences put a stuff-pattern candidate at frame index `last_pos`+16 and at `last_pos`+17, which pins down the exact edge of the tail cut-off. A frame-done pulse in the middle of a run, followed by a short run, shows whether history and index are cleared and whether the five-bit warm-up is honoured.

// File: rtl/can_dstf_pkg.sv
package can_dstf_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_FRAME = 2'd1,
    KIND_STUFF = 2'd2
  } bit_kind_t;
endpackage

// File: rtl/dstf_history.sv
module dstf_history #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift,
  input  logic din,
  output logic run_full,
  output logic run_equal,
  output logic run_val
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [RUN_LEN-1:0] hist_q;
  logic [CNT_W-1:0]   fill_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift) begin
      hist_q <= {hist_q[RUN_LEN-2:0], din};
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  assign run_full  = (fill_q == FULL);
  assign run_equal = (&hist_q) | (~|hist_q);
  assign run_val   = hist_q[0];

  // R7: the warm-up counter never passes the window length
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FULL);

  // R6: every accepted raw bit, stuff or not, enters the window
  p_raw_enters_r6: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr) |=> (hist_q[0] == $past(din)));

  // R10: clear empties the window
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill_q == '0));
endmodule

// File: rtl/dstf_tail_gate.sv
module dstf_tail_gate #(
  parameter int IDX_W = 10,
  parameter int TAIL  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [IDX_W-1:0] pos,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             enable
);
  localparam int SUM_W = IDX_W + 1;
  localparam logic [SUM_W-1:0] TAIL_W = SUM_W'(TAIL);

  logic [IDX_W-1:0] last_q;
  logic             known_q;
  logic [SUM_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_q  <= '0;
      known_q <= 1'b0;
    end else if (set) begin
      last_q  <= pos;
      known_q <= 1'b1;
    end
  end

  assign limit  = {1'b0, last_q} + TAIL_W;
  assign enable = !known_q || ({1'b0, cur_idx} <= limit);

  // R10: a clear forgets the loaded position, so detection is back on
  p_clear_enables_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> enable);
endmodule

// File: rtl/dstf_classify.sv
module dstf_classify
  import can_dstf_pkg::*;
(
  input  logic      vld,
  input  logic      drop,
  input  logic      din,
  input  logic      run_full,
  input  logic      run_equal,
  input  logic      run_val,
  input  logic      enable,
  output bit_kind_t kind
);
  logic pattern;

  assign pattern = run_full && run_equal && (din != run_val);

  always_comb begin
    kind = KIND_NONE;
    if (vld && !drop) begin
      if (pattern && enable) kind = KIND_STUFF;
      else                   kind = KIND_FRAME;
    end
  end
endmodule

// File: rtl/can_bit_destuffer.sv
module can_bit_destuffer
  import can_dstf_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int RUN_LEN = 5,
  parameter int TAIL    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_vld,
  input  logic             raw_bit,
  input  logic             last_set,
  input  logic [IDX_W-1:0] last_pos,
  input  logic             frame_done,
  output logic             frm_vld,
  output logic             frm_bit,
  output logic [IDX_W-1:0] frm_idx,
  output logic             stf_vld
);
  logic             run_full, run_equal, run_val, enable;
  logic [IDX_W-1:0] fcnt_q;
  bit_kind_t        kind;

  dstf_history #(.RUN_LEN(RUN_LEN)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .clr       (frame_done),
    .shift     (raw_vld),
    .din       (raw_bit),
    .run_full  (run_full),
    .run_equal (run_equal),
    .run_val   (run_val)
  );

  dstf_tail_gate #(.IDX_W(IDX_W), .TAIL(TAIL)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .clr     (frame_done),
    .set     (last_set),
    .pos     (last_pos),
    .cur_idx (fcnt_q),
    .enable  (enable)
  );

  dstf_classify u_cls (
    .vld       (raw_vld),
    .drop      (frame_done),
    .din       (raw_bit),
    .run_full  (run_full),
    .run_equal (run_equal),
    .run_val   (run_val),
    .enable    (enable),
    .kind      (kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_vld <= 1'b0;
      frm_bit <= 1'b0;
      frm_idx <= '0;
      stf_vld <= 1'b0;
      fcnt_q  <= '0;
    end else begin
      frm_vld <= (kind == KIND_FRAME);
      stf_vld <= (kind == KIND_STUFF);
      if (frame_done) begin
        fcnt_q <= '0;
      end else if (kind == KIND_FRAME) begin
        frm_bit <= raw_bit;
        frm_idx <= fcnt_q;
        fcnt_q  <= fcnt_q + 1'b1;
      end
    end
  end

  // R11: a bit is reported as one kind only
  p_one_kind_r11: assert property (@(posedge clk) disable iff (rst)
    !(frm_vld && stf_vld));

  // R2: every output pulse follows an accepted raw bit by one clock
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (frm_vld || stf_vld) |-> $past(raw_vld));

  // R2: every accepted raw bit yields one pulse unless dropped
  p_no_loss_r2: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && !frame_done) |=> (frm_vld || stf_vld));

  // R4: a removed bit leaves the reported index untouched
  p_stuff_holds_idx_r4: assert property (@(posedge clk) disable iff (rst)
    stf_vld |-> $stable(frm_idx));

  // R10: nothing is reported for the cycle of a frame-done
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !(frm_vld || stf_vld));
endmodule

// File: tb/sim_can_bit_destuffer.sv
module sim_can_bit_destuffer;
  localparam int IDX_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             raw_vld = 1'b0;
  logic             raw_bit = 1'b0;
  logic             last_set = 1'b0;
  logic [IDX_W-1:0] last_pos = '0;
  logic             frame_done = 1'b0;
  logic             frm_vld, frm_bit, stf_vld;
  logic [IDX_W-1:0] frm_idx;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_bit_destuffer #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .raw_vld(raw_vld), .raw_bit(raw_bit),
    .last_set(last_set), .last_pos(last_pos), .frame_done(frame_done),
    .frm_vld(frm_vld), .frm_bit(frm_bit), .frm_idx(frm_idx), .stf_vld(stf_vld)
  );

  // entry: {raw bit, forwarded?, expected index}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 10'd0},  {1'b0, 1'b1, 10'd1},  {1'b0, 1'b1, 10'd2},
    {1'b0, 1'b1, 10'd3},  {1'b0, 1'b1, 10'd4},
    {1'b1, 1'b0, 10'd4},                                   // R4 stuff after 0s
    {1'b1, 1'b1, 10'd5},  {1'b1, 1'b1, 10'd6},  {1'b1, 1'b1, 10'd7},
    {1'b1, 1'b1, 10'd8},
    {1'b0, 1'b0, 10'd8},                                   // R6 run includes stuff
    {1'b0, 1'b1, 10'd9},  {1'b0, 1'b1, 10'd10}, {1'b0, 1'b1, 10'd11},
    {1'b0, 1'b1, 10'd12},
    {1'b0, 1'b1, 10'd13},                                  // R5 sixth equal bit
    {1'b1, 1'b0, 10'd13},                                  // R4 stuff
    {1'b1, 1'b1, 10'd14}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one raw bit at a falling edge, sample one cycle after acceptance
  task automatic send(input logic b, input bit fwd, input int idx, input string req);
    raw_vld = 1'b1;
    raw_bit = b;
    @(posedge clk);
    @(negedge clk);
    raw_vld = 1'b0;
    if (fwd) begin
      check(frm_vld == 1'b1 && stf_vld == 1'b0, req, "frame strobe", frm_vld, 1);
      check(frm_bit == b, req, "frame bit", frm_bit, b);
      check(frm_idx == idx, req, "frame index", frm_idx, idx);
    end else begin
      check(stf_vld == 1'b1 && frm_vld == 1'b0, req, "stuff strobe", stf_vld, 1);
      check(frm_idx == idx, req, "index held", frm_idx, idx);
    end
  endtask

  task automatic pulse_done();
    frame_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic load_last(input int p);
    last_set = 1'b1;
    last_pos = IDX_W'(p);
    @(posedge clk);
    @(negedge clk);
    last_set = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(frm_vld == 1'b0 && stf_vld == 1'b0, "R1", "strobes in reset", frm_vld | stf_vld, 0);
    check(frm_idx == '0, "R1", "index in reset", frm_idx, 0);
    rst = 1'b0;
    @(negedge clk);
    check(frm_vld == 1'b0 && stf_vld == 1'b0, "R1", "strobes after reset", frm_vld | stf_vld, 0);

    // table walk: R3 R4 R5 R6 R8 (no last position loaded)
    for (int i = 0; i < NV; i++)
      send(VEC[i][11], VEC[i][10], int'(VEC[i][9:0]), "R4/R3/R5/R6/R8");

    // R2: idle cycle produces no pulse
    @(negedge clk);
    check(frm_vld == 1'b0 && stf_vld == 1'b0, "R2", "idle quiet", frm_vld | stf_vld, 0);

    // R10 + R7: frame-done mid-run clears history and index
    pulse_done();
    send(1'b0, 1'b1, 0, "R10");
    send(1'b0, 1'b1, 1, "R10");
    send(1'b0, 1'b1, 2, "R10");
    raw_vld = 1'b1; raw_bit = 1'b0;        // R10: bit with frame-done is dropped
    frame_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    raw_vld = 1'b0; frame_done = 1'b0;
    check(frm_vld == 1'b0 && stf_vld == 1'b0, "R10", "dropped with done", frm_vld | stf_vld, 0);
    for (int i = 0; i < 4; i++) send(1'b0, 1'b1, i, "R10");
    send(1'b1, 1'b1, 4, "R7");             // only four raw bits so far

    // R9: candidate at last+16 is still stuff-checked
    pulse_done();
    load_last(0);
    for (int i = 0; i < 11; i++) send(logic'(i % 2), 1'b1, i, "R9");
    for (int i = 11; i < 16; i++) send(1'b0, 1'b1, i, "R9");
    send(1'b1, 1'b0, 15, "R9");

    // R9: candidate at last+17 is forwarded
    pulse_done();
    load_last(0);
    for (int i = 0; i < 12; i++) send(logic'(i % 2), 1'b1, i, "R9");
    for (int i = 12; i < 17; i++) send(1'b0, 1'b1, i, "R9");
    send(1'b1, 1'b1, 17, "R9");

    // R10: frame-done forgets last position, R8 detection on again at high index
    pulse_done();
    for (int i = 0; i < 12; i++) send(logic'(i % 2), 1'b1, i, "R8");
    for (int i = 12; i < 17; i++) send(1'b0, 1'b1, i, "R8");
    send(1'b1, 1'b0, 16, "R8");

    // R11: no double strobe on the next cycle
    @(negedge clk);
    check(!(frm_vld && stf_vld), "R11", "exclusive strobes", frm_vld & stf_vld, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule